// File: doc/BRIEF.md
# Burst-Coalescing Miss Handler

This block tracks outstanding read misses from a narrow accelerator port and turns them into variable-length bursts of whole lines for a wide memory port. Line addresses are grouped into aligned regions of `BURST_MAX` lines. Each region can be held by at most one live miss register. That register keeps the lowest and highest line offset wanted so far. Every accepted request becomes a subentry that holds the requester ID, the line offset inside the region, and the word offset inside the line.

A miss to a region with no live register opens a one-line burst. A miss to a line already inside the bounds adds only a subentry. A miss outside the bounds widens the burst in place while it still waits in the output queue. If the burst has already left the queue, the old burst is cancelled and a widened one is queued again. The register then counts how many beats of the cancelled burst are still to come and discards them.

Returning lines arrive one beat per line, in address order, tagged with the register index. Each beat is handed out one subentry per cycle to every subentry waiting on that line. The register is released after the last beat of its live burst. Every request is assumed to be a cache miss. The cache array itself is not part of the block.

Top module: `mshr_burst_coalescer`

## Requirements
- R1: A request to a region with no live register is accepted, claims a register, and queues a burst whose start line is the request's line and whose `mem_len` is 1. `mem_len` always counts lines.
- R2: A request whose line lies inside a live burst's bounds, and has not yet been delivered, adds a subentry and creates no additional memory request.
- R3: A request outside the bounds of a burst that is still queued widens that burst in place, so that the start is the lowest and the end the highest line requested. While `mem_valid` is high and not accepted, the presented tag is held and `mem_len` never shrinks.
- R4: A request outside the bounds of a burst already accepted by memory queues a new widened burst for the same register. The beats still owed by the cancelled burst are consumed without producing any output.
- R5: For each live beat, every subentry whose line equals the beat's line (the burst start plus the number of live beats already received) gets `out_id` equal to its requester ID and `out_word` equal to bits `[w*WORD_W +: WORD_W]` of `rsp_data`, where w is its word offset. This happens exactly once per subentry, one per cycle, and never without `rsp_valid`.
- R6: After the last beat of its live burst, a register is released. A later miss to the same region then issues a fresh burst.
- R7: When no register is free for a new region, or no subentry slot is free, `req_ready` is low. The request waits and is accepted later; it is never dropped.
- R8: Every burst lies inside one aligned region: 1 ≤ `mem_len` ≤ `BURST_MAX`, and start offset plus `mem_len` ≤ `BURST_MAX`.
- R9: While more than one subentry still waits on the current beat, `rsp_ready` stays low. Only the cycle that serves the final waiting subentry accepts the beat.
- R10: After reset, `req_ready` is high and `mem_valid` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Miss request accepted this cycle |
| req_line | input | LINE_AW | Line address of the miss |
| req_off | input | log2(WORDS) | Word offset inside the line |
| req_id | input | ID_W | Requester ID |
| mem_valid | output | 1 | Burst request present |
| mem_ready | input | 1 | Memory accepts the burst |
| mem_line | output | LINE_AW | First line of the burst |
| mem_len | output | log2(BURST_MAX)+1 | Number of lines in the burst |
| mem_tag | output | log2(REGS) | Register index of the burst |
| rsp_valid | input | 1 | Returning line beat present |
| rsp_ready | output | 1 | Beat consumed this cycle |
| rsp_tag | input | log2(REGS) | Register index of the beat |
| rsp_data | input | WORDS*WORD_W | Line data |
| out_valid | output | 1 | Word delivered to a requester |
| out_id | output | ID_W | Requester ID of the delivered word |
| out_word | output | WORD_W | Delivered word |

## Verification
The assertions assume that memory returns each accepted burst as exactly `mem_len` beats, that beats for one tag come back in the order their bursts were accepted, and that `rsp_tag` only names a register with an accepted burst. The stimulus honours this by modelling memory as one in-order queue: every accepted burst is replayed beat by beat, with the data of each line computed from its address. Random gaps on `mem_ready` and `rsp_valid` vary the timing, but the queue never reorders or truncates a burst.

// File: rtl/mshr_pkg.sv
// Shared types for the burst-coalescing miss handler.
package mshr_pkg;
    // Lifecycle of one miss register's burst.
    typedef enum logic [1:0] {
        BS_FREE   = 2'd0,
        BS_QUEUED = 2'd1,
        BS_ISSUED = 2'd2
    } bstate_e;
endpackage

// File: rtl/mshr_pick.sv
// Lowest-index picker: reports whether any bit is set and the index of the
// lowest set bit. Assumes W >= 2.
module mshr_pick #(
    parameter int W  = 4,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so that the lowest set bit wins.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/mshr_idx_fifo.sv
// Output request queue holding register indices only. The burst bounds are
// read from the register when the head is presented, so a queued burst can
// grow without touching the queue. Assumes DEPTH is a power of two and the
// producer never pushes into a full queue (one entry per register at most).
module mshr_idx_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] slot [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] fill;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            fill <= fill + CW'(push) - CW'(pop);
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) slot[wr_ptr] <= push_data;
    end

    assign out_valid = (fill != '0);
    assign out_data  = slot[rd_ptr];
endmodule

// File: rtl/mshr_burst_coalescer.sv
// Burst-coalescing miss handler. Assumes every request is a miss. Memory
// returns each accepted burst as mem_len beats in line order, bursts of one
// tag in acceptance order, and rsp_tag only names an issued register.
// REGS and SUBS are powers of two; BURST_MAX is 2, 4, 8 or 16.
module mshr_burst_coalescer
    import mshr_pkg::*;
#(
    parameter int LINE_AW   = 12,
    parameter int BURST_MAX = 4,
    parameter int REGS      = 4,
    parameter int SUBS      = 8,
    parameter int ID_W      = 4,
    parameter int WORDS     = 4,
    parameter int WORD_W    = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [LINE_AW-1:0]            req_line,
    input  logic [$clog2(WORDS)-1:0]      req_off,
    input  logic [ID_W-1:0]               req_id,
    output logic                          mem_valid,
    input  logic                          mem_ready,
    output logic [LINE_AW-1:0]            mem_line,
    output logic [$clog2(BURST_MAX):0]    mem_len,
    output logic [$clog2(REGS)-1:0]       mem_tag,
    input  logic                          rsp_valid,
    output logic                          rsp_ready,
    input  logic [$clog2(REGS)-1:0]       rsp_tag,
    input  logic [WORDS*WORD_W-1:0]       rsp_data,
    output logic                          out_valid,
    output logic [ID_W-1:0]               out_id,
    output logic [WORD_W-1:0]             out_word
);
    localparam int LB    = $clog2(BURST_MAX);
    localparam int RW    = LINE_AW - LB;
    localparam int RI    = $clog2(REGS);
    localparam int SI    = $clog2(SUBS);
    localparam int OFW   = $clog2(WORDS);
    localparam int LEN_W = LB + 1;

    // Miss registers.
    bstate_e          st       [REGS];
    logic [RW-1:0]    reg_rgn  [REGS];
    logic [LB-1:0]    lo       [REGS];
    logic [LB-1:0]    hi       [REGS];
    logic [LB-1:0]    cnt      [REGS];
    logic [LEN_W-1:0] stale    [REGS];

    // Subentries.
    logic [SUBS-1:0]  sub_valid;
    logic [RI-1:0]    sub_reg  [SUBS];
    logic [LB-1:0]    sub_lb   [SUBS];
    logic [OFW-1:0]   sub_off  [SUBS];
    logic [ID_W-1:0]  sub_id   [SUBS];

    logic [RW-1:0]    req_rgn;
    logic [LB-1:0]    req_lb;
    logic [REGS-1:0]  hit_vec, free_reg_vec;
    logic [SUBS-1:0]  match;
    logic             hit_any, free_reg_any, sub_any, m_any;
    logic [RI-1:0]    h, free_reg_idx;
    logic [SI-1:0]    sub_idx, m_idx;
    logic             in_bounds, delivered, blocked, popping;
    logic             acc, new_alloc, extend, reissue, push;
    logic [LB-1:0]    cur_lb, nlo, nhi;
    logic             stale_beat, beat_acc, beat_live, beat_last;
    logic [LEN_W-1:0] owed;

    assign req_rgn = req_line[LINE_AW-1:LB];
    assign req_lb  = req_line[LB-1:0];

    // Region lookup and free-register scan.
    always_comb begin
        for (int r = 0; r < REGS; r++) begin
            hit_vec[r]      = (st[r] != BS_FREE) && (reg_rgn[r] == req_rgn);
            free_reg_vec[r] = (st[r] == BS_FREE);
        end
    end

    mshr_pick #(.W(REGS)) u_hit  (.vec(hit_vec),      .found(hit_any),      .idx(h));
    mshr_pick #(.W(REGS)) u_freg (.vec(free_reg_vec), .found(free_reg_any), .idx(free_reg_idx));
    mshr_pick #(.W(SUBS)) u_fsub (.vec(~sub_valid),   .found(sub_any),      .idx(sub_idx));

    // Acceptance decision for the incoming miss.
    always_comb begin
        popping   = mem_valid && mem_ready;
        in_bounds = (req_lb >= lo[h]) && (req_lb <= hi[h]);
        delivered = ({1'b0, req_lb} < ({1'b0, lo[h]} + {1'b0, cnt[h]}));
        blocked   = (rsp_valid && (rsp_tag == h)) ||
                    (popping && (mem_tag == h)) ||
                    ((st[h] == BS_ISSUED) && (in_bounds ? delivered : (stale[h] != '0)));
        req_ready = sub_any && (hit_any ? !blocked : free_reg_any);
        acc       = req_valid && req_ready;
        new_alloc = acc && !hit_any;
        extend    = acc && hit_any && !in_bounds;
        reissue   = extend && (st[h] == BS_ISSUED);
        push      = new_alloc || reissue;
        nlo       = (req_lb < lo[h]) ? req_lb : lo[h];
        nhi       = (req_lb > hi[h]) ? req_lb : hi[h];
        owed      = ({1'b0, hi[h]} - {1'b0, lo[h]} + 1'b1) - {1'b0, cnt[h]};
    end

    mshr_idx_fifo #(.DEPTH(REGS), .DW(RI)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(new_alloc ? free_reg_idx : h),
        .pop(popping),
        .out_valid(mem_valid), .out_data(mem_tag)
    );

    assign mem_line = {reg_rgn[mem_tag], lo[mem_tag]};
    assign mem_len  = {1'b0, hi[mem_tag]} - {1'b0, lo[mem_tag]} + 1'b1;

    // Beat decode: which subentries wait on the line now returning.
    always_comb begin
        cur_lb     = lo[rsp_tag] + cnt[rsp_tag];
        stale_beat = (stale[rsp_tag] != '0);
        for (int s = 0; s < SUBS; s++) begin
            match[s] = sub_valid[s] && (sub_reg[s] == rsp_tag) && (sub_lb[s] == cur_lb);
        end
    end

    mshr_pick #(.W(SUBS)) u_match (.vec(match), .found(m_any), .idx(m_idx));

    // Fan-out of one beat, one subentry per cycle.
    always_comb begin
        rsp_ready = stale_beat || ($countones(match) <= 1);
        out_valid = rsp_valid && !stale_beat && m_any;
        out_id    = sub_id[m_idx];
        out_word  = rsp_data[sub_off[m_idx]*WORD_W +: WORD_W];
        beat_acc  = rsp_valid && rsp_ready;
        beat_live = beat_acc && !stale_beat;
        beat_last = beat_live && (cnt[rsp_tag] == (hi[rsp_tag] - lo[rsp_tag]));
    end

    // Register lifecycle: allocate, widen, issue, count beats, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < REGS; r++) begin
                st[r]      <= BS_FREE;
                reg_rgn[r] <= '0;
                lo[r]      <= '0;
                hi[r]      <= '0;
                cnt[r]     <= '0;
                stale[r]   <= '0;
            end
        end else begin
            for (int r = 0; r < REGS; r++) begin
                if (popping && (mem_tag == RI'(r))) st[r] <= BS_ISSUED;
                if (beat_acc && (rsp_tag == RI'(r))) begin
                    if (stale_beat)     stale[r] <= stale[r] - 1'b1;
                    else if (beat_last) st[r]    <= BS_FREE;
                    else                cnt[r]   <= cnt[r] + 1'b1;
                end
                if (new_alloc && (free_reg_idx == RI'(r))) begin
                    st[r]      <= BS_QUEUED;
                    reg_rgn[r] <= req_rgn;
                    lo[r]      <= req_lb;
                    hi[r]      <= req_lb;
                    cnt[r]     <= '0;
                    stale[r]   <= '0;
                end
                if (extend && (h == RI'(r))) begin
                    lo[r] <= nlo;
                    hi[r] <= nhi;
                    if (reissue) begin
                        st[r]    <= BS_QUEUED;
                        cnt[r]   <= '0;
                        stale[r] <= owed;
                    end
                end
            end
        end
    end

    // Subentry occupancy: claim on accept, release on delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_valid <= '0;
        end else begin
            if (out_valid) sub_valid[m_idx] <= 1'b0;
            if (acc)       sub_valid[sub_idx] <= 1'b1;
        end
    end

    // Subentry payload capture.
    always_ff @(posedge clk) begin
        if (acc) begin
            sub_reg[sub_idx] <= hit_any ? h : free_reg_idx;
            sub_lb[sub_idx]  <= req_lb;
            sub_off[sub_idx] <= req_off;
            sub_id[sub_idx]  <= req_id;
        end
    end
endmodule

// File: rtl/mshr_chk.sv
// Property checker for the burst-coalescing miss handler, bound to the top.
// Assumes the input conventions stated in the top module header.
module mshr_chk #(
    parameter int LINE_AW   = 12,
    parameter int BURST_MAX = 4,
    parameter int REGS      = 4,
    parameter int SUBS      = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_ready,
    input logic                       mem_valid,
    input logic                       mem_ready,
    input logic [LINE_AW-1:0]         mem_line,
    input logic [$clog2(BURST_MAX):0] mem_len,
    input logic [$clog2(REGS)-1:0]    mem_tag,
    input logic                       rsp_valid,
    input logic                       out_valid,
    input logic [REGS-1:0]            hit_vec,
    input logic [SUBS-1:0]            sub_valid
);
    localparam int LB = $clog2(BURST_MAX);

    // R10: one cycle after reset the block is idle and ready.
    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !mem_valid && !out_valid));

    // R8: a presented burst stays inside its aligned region.
    a_r8_burst_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((mem_len != '0) &&
                       ((32'(mem_line[LB-1:0]) + 32'(mem_len)) <= BURST_MAX)));

    // R3: a waiting burst keeps its tag and only grows.
    a_r3_grow_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && (mem_tag == $past(mem_tag)) && (mem_len >= $past(mem_len))));

    // R5: a word is only delivered while a beat is present.
    a_r5_out_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> rsp_valid);

    // R2: at most one live register covers any region.
    a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R7: with every subentry taken, no request is accepted.
    a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (&sub_valid) |-> !req_ready);
endmodule

bind mshr_burst_coalescer mshr_chk #(
    .LINE_AW(LINE_AW), .BURST_MAX(BURST_MAX), .REGS(REGS), .SUBS(SUBS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_line(mem_line),
    .mem_len(mem_len), .mem_tag(mem_tag), .rsp_valid(rsp_valid),
    .out_valid(out_valid), .hit_vec(hit_vec), .sub_valid(sub_valid)
);

// File: tb/tb_mshr_burst_coalescer.sv
// Self-checking bench: in-order memory model, directed corners, random mix.
module tb_mshr_burst_coalescer;
    localparam int LINE_AW = 12, BURST_MAX = 4, REGS = 4, SUBS = 8;
    localparam int ID_W = 4, WORDS = 4, WORD_W = 16;
    localparam int NID = 1 << ID_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [LINE_AW-1:0] req_line = '0;
    logic [1:0] req_off = '0;
    logic [ID_W-1:0] req_id = '0;
    logic mem_valid, mem_ready = 1'b0;
    logic [LINE_AW-1:0] mem_line;
    logic [2:0] mem_len;
    logic [1:0] mem_tag;
    logic rsp_valid = 1'b0, rsp_ready;
    logic [1:0] rsp_tag = '0;
    logic [WORDS*WORD_W-1:0] rsp_data = '0;
    logic out_valid;
    logic [ID_W-1:0] out_id;
    logic [WORD_W-1:0] out_word;

    mshr_burst_coalescer dut (.*);

    always #5 clk = ~clk;

    int n_run = 0, n_fail = 0;
    logic outstanding [NID];
    int exp_line [NID], exp_off [NID];
    int n_open = 0, n_out = 0, n_beats = 0, hold_cnt = 0, mem_cnt = 0;
    int last_line = 0, last_len = 0;
    bit mem_go = 0, rsp_go = 0;
    int bq_line [$], bq_len [$], bq_tag [$];
    int beat_i = 0;

    function automatic logic [WORD_W-1:0] wfn(int line, int w);
        return WORD_W'((line * 37 + w * 11 + 'h5A) & 'hFFFF);
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Memory model: accept bursts, replay them beat by beat in order.
    initial begin
        for (int i = 0; i < NID; i++) outstanding[i] = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_valid && mem_ready) begin
                bq_line.push_back(int'(mem_line));
                bq_len.push_back(int'(mem_len));
                bq_tag.push_back(int'(mem_tag));
                mem_cnt++;
                last_line = int'(mem_line);
                last_len  = int'(mem_len);
                chk(mem_len >= 1 && mem_len <= BURST_MAX &&
                    (int'(mem_line[1:0]) + int'(mem_len)) <= BURST_MAX,
                    "R8 burst outside region", int'(mem_len), BURST_MAX);
            end
            if (rst_n && rsp_valid && rsp_ready) begin
                n_beats++;
                beat_i++;
                if (beat_i == bq_len[0]) begin
                    beat_i = 0;
                    void'(bq_line.pop_front());
                    void'(bq_len.pop_front());
                    void'(bq_tag.pop_front());
                end
            end
            @(posedge clk);
            #1;
            mem_ready = mem_go && ($urandom % 4 != 0);
            rsp_valid = rsp_go && (bq_line.size() != 0) && ($urandom % 4 != 0);
            if (bq_line.size() != 0) begin
                rsp_tag = 2'(bq_tag[0]);
                for (int w = 0; w < WORDS; w++)
                    rsp_data[w*WORD_W +: WORD_W] = wfn(bq_line[0] + beat_i, w);
            end
        end
    end

    // Delivery monitor: every word must match its requester's line and offset.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (!outstanding[out_id]) begin
                chk(0, "R5 delivery to idle id", int'(out_id), -1);
            end else begin
                chk(out_word == wfn(exp_line[out_id], exp_off[out_id]), "R5 word",
                    int'(out_word), int'(wfn(exp_line[out_id], exp_off[out_id])));
                outstanding[out_id] = 1'b0;
                n_open--;
                n_out++;
            end
            if (rsp_valid && !rsp_ready) hold_cnt++;
        end
    end

    task automatic send(int line, int off, int id);
        @(posedge clk); #1;
        req_valid = 1'b1; req_line = LINE_AW'(line);
        req_off = 2'(off); req_id = ID_W'(id);
        forever begin
            @(negedge clk);
            if (req_ready) begin
                outstanding[id] = 1'b1;
                exp_line[id] = line;
                exp_off[id] = off;
                n_open++;
                break;
            end
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain(string tag);
        int k;
        for (k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (n_open == 0 && bq_line.size() == 0 && !mem_valid) break;
        end
        chk(k < 5000, tag, n_open, 0);
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        int base, id;
        void'($urandom(32'd4711));
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset.
        chk(req_ready == 1'b1, "R10 req_ready", int'(req_ready), 1);
        chk(mem_valid == 1'b0, "R10 mem_valid", int'(mem_valid), 0);
        chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);

        // R1, R2, R3: memory held, burst builds up in the queue.
        send('h40, 1, 1);
        @(negedge clk);
        chk(mem_valid && mem_line == 'h40 && mem_len == 1, "R1 new burst", int'(mem_len), 1);
        send('h40, 3, 2);
        @(negedge clk);
        chk(mem_line == 'h40 && mem_len == 1, "R2 in-bounds join", int'(mem_len), 1);
        send('h42, 2, 3);
        @(negedge clk);
        chk(mem_line == 'h40 && mem_len == 3, "R3 widened in place", int'(mem_len), 3);
        base = mem_cnt;
        mem_go = 1; rsp_go = 1;
        drain("R5 drain first burst");
        chk(mem_cnt - base == 1, "R2 single request", mem_cnt - base, 1);
        chk(n_out == 3, "R5 three deliveries", n_out, 3);

        // R6: region freed, fresh burst issued.
        mem_go = 0; rsp_go = 0;
        wait_cycles(2);
        send('h41, 0, 4);
        @(negedge clk);
        chk(mem_valid && mem_line == 'h41 && mem_len == 1, "R6 fresh burst", int'(mem_line), 'h41);
        mem_go = 1; rsp_go = 1;
        drain("R6 drain");

        // R4: issued burst is cancelled and reissued wider.
        rsp_go = 0;
        base = mem_cnt;
        send('h80, 0, 5);
        while (mem_cnt == base) @(negedge clk);
        send('h82, 3, 6);
        while (mem_cnt == base + 1) @(negedge clk);
        chk(last_line == 'h80 && last_len == 3, "R4 reissued burst", last_len, 3);
        n_out = 0;
        rsp_go = 1;
        drain("R4 drain");
        chk(n_out == 2, "R4 stale beat silent", n_out, 2);

        // R9: one beat fanned out to three waiting subentries.
        rsp_go = 0;
        send('hC1, 0, 7);
        send('hC1, 1, 8);
        send('hC1, 2, 9);
        wait_cycles(10);
        n_out = 0; n_beats = 0; hold_cnt = 0;
        rsp_go = 1;
        drain("R9 drain");
        chk(n_beats == 1, "R9 one beat", n_beats, 1);
        chk(n_out == 3, "R9 three deliveries", n_out, 3);
        chk(hold_cnt == 2, "R9 beat held", hold_cnt, 2);

        // R7: all registers busy.
        mem_go = 0; rsp_go = 0;
        wait_cycles(2);
        for (int i = 0; i < REGS; i++) send('h200 + 4 * i, 0, i);
        @(posedge clk); #1;
        req_valid = 1'b1; req_line = 'h210; req_off = 2'd1; req_id = ID_W'(REGS);
        @(negedge clk);
        chk(req_ready == 1'b0, "R7 no free register", int'(req_ready), 0);
        @(posedge clk); #1 req_valid = 1'b0;
        mem_go = 1; rsp_go = 1;
        send('h210, 1, REGS);
        drain("R7 register stall released");

        // R7: all subentries busy.
        mem_go = 0; rsp_go = 0;
        wait_cycles(2);
        for (int i = 0; i < SUBS; i++) send('h300, i % WORDS, i);
        @(posedge clk); #1;
        req_valid = 1'b1; req_line = 'h301; req_off = 2'd0; req_id = ID_W'(SUBS);
        @(negedge clk);
        chk(req_ready == 1'b0, "R7 no free subentry", int'(req_ready), 0);
        @(posedge clk); #1 req_valid = 1'b0;
        mem_go = 1; rsp_go = 1;
        send('h301, 0, SUBS);
        drain("R7 subentry stall released");

        // Random mix over eight regions: R2, R3, R4, R5, R7, R8.
        for (int n = 0; n < 400; n++) begin
            id = -1;
            while (id < 0) begin
                int st = $urandom % NID;
                for (int k = 0; k < NID; k++)
                    if (id < 0 && !outstanding[(st + k) % NID]) id = (st + k) % NID;
                if (id < 0) @(negedge clk);
            end
            send($urandom % 32, $urandom % WORDS, id);
        end
        drain("R5 random drain");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule